// File: doc/BRIEF.md
# Vector Narrowing Unit with Operand Tags

This unit halves the element width of integer operands. In vector form it takes two operand vectors of equal element width and packs their narrowed elements into a single result vector. The result holds twice as many elements at half the width, so the element count of the two inputs is kept. In scalar form it takes one operand and returns its narrowed value in the low bits. Each operand carries a width code and two per-element tags, None and NaR. Narrowing treats tagged elements like any other data, and the result element keeps the tag.

A per-operation mode chooses what happens when a value does not fit the narrow width: the low bits are kept, the operation faults, or the value is clamped. A separate control bit says whether elements are signed or unsigned. Operands that cannot be narrowed fault at once and produce no data. This covers operands already at the smallest width, a width mismatch between the two vector inputs, and the unused mode code. The result appears one clock after the request in every case.

Top module: `vec_narrow_unit`

## Requirements
- R1: In vector form, input element k of operand A becomes output element k, and input element k of operand B becomes output element N+k, where N is the input element count. The output width code is the input code minus one, and out_valid rises in the cycle after the in_valid request.
- R2: Width codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An operand with code 0 raises out_fault.
- R3: In vector form, a_wcode different from b_wcode raises out_fault.
- R4: Mode 0 (truncate) keeps the low half of each element, even on overflow.
- R5: Mode 1 (fault) raises out_fault if any element overflows the narrow width.
- R6: Mode 2 (saturate) clamps an overflowing element. When signed, it clamps to the most positive or most negative narrow value. When unsigned, it clamps to all ones.
- R7: Mode code 3 is illegal and raises out_fault.
- R8: in_signed = 1 means an element overflows unless its upper half repeats the narrow sign bit. in_signed = 0 means an element overflows when its upper half is nonzero.
- R9: The tag of an input element is read from the tag bit at that element's lowest byte lane. Other tag bits are ignored. Each output tag is placed at the lowest byte lane of its output element, and all other output tag bits are zero.
- R10: In scalar form (in_scalar = 1), only the low half-width bytes of operand A's element 0 reach the output. All higher data bytes and all tags except lane 0 are zero. Operand B and its width code are ignored, and only that element is checked for overflow.
- R11: After reset, all outputs are zero.
- R12: A faulting request gives out_fault for one cycle, with out_valid low and zero data, width code and tags. A cycle without in_valid gives out_valid and out_fault both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_scalar | input | 1 | 1 = scalar form, 0 = vector form |
| in_signed | input | 1 | Signedness used for overflow and clamping |
| in_mode | input | 2 | Overflow mode: 0 truncate, 1 fault, 2 saturate |
| a_data | input | 128 | Operand A elements, little-endian |
| a_wcode | input | 2 | Operand A width code |
| a_none | input | 16 | Operand A None tags per byte lane |
| a_nar | input | 16 | Operand A NaR tags per byte lane |
| b_data | input | 128 | Operand B elements |
| b_wcode | input | 2 | Operand B width code |
| b_none | input | 16 | Operand B None tags per byte lane |
| b_nar | input | 16 | Operand B NaR tags per byte lane |
| out_valid | output | 1 | Result valid |
| out_fault | output | 1 | Fault strobe |
| y_data | output | 128 | Narrowed result |
| y_wcode | output | 2 | Result width code |
| y_none | output | 16 | Result None tags |
| y_nar | output | 16 | Result NaR tags |

## Verification
The bench builds the unit with its default 16-byte vector. With that size, all three narrowing widths (8 to 4, 4 to 2 and 2 to 1 bytes) can be reached, and each has at least two elements per operand. The element-order tests can therefore show how both operands are split across the two halves of the result. Tag tests at the 4-byte width put tags on base lanes and on non-base lanes. This shows that only base lanes are read, and that the output base lanes move by half an element.

// File: rtl/vn_pkg.sv
// Shared types for the vector narrowing unit.
// Assumes width codes are log2 of the element byte count.
package vn_pkg;
    typedef enum logic [1:0] {WC_1B = 2'd0, WC_2B = 2'd1, WC_4B = 2'd2, WC_8B = 2'd3} wcode_t;
    typedef enum logic [1:0] {OV_TRUNC = 2'd0, OV_FAULT = 2'd1, OV_SAT = 2'd2, OV_RSV = 2'd3} ovmode_t;
endpackage

// File: rtl/vn_elem.sv
// Narrows one element to half its width and reports overflow.
// Applies clamping when sat is set; assumes IN_BITS is even.
module vn_elem #(
    parameter int IN_BITS = 32
) (
    input  logic [IN_BITS-1:0]   din,
    input  logic                 sgn,
    input  logic                 sat,
    output logic [IN_BITS/2-1:0] dout,
    output logic                 ovf
);
    localparam int OB = IN_BITS / 2;

    logic [OB-1:0] hi_half;
    logic [OB-1:0] lo_half;
    assign hi_half = din[IN_BITS-1:OB];
    assign lo_half = din[OB-1:0];

    // Overflow test and clamped or truncated result
    always_comb begin
        if (sgn) ovf = (hi_half != {OB{lo_half[OB-1]}});
        else     ovf = (hi_half != '0);
        dout = lo_half;
        if (sat && ovf) begin
            if (sgn) dout = din[IN_BITS-1] ? {1'b1, {(OB-1){1'b0}}} : {1'b0, {(OB-1){1'b1}}};
            else     dout = '1;
        end
    end
endmodule

// File: rtl/vn_pack.sv
// Narrows every element of two operands at one fixed input width.
// Packs A into the low half of the result and B into the high half.
// Tags are read from and written to element base lanes.
module vn_pack #(
    parameter int VEC_BYTES = 16,
    parameter int IN_BYTES  = 4
) (
    input  logic [VEC_BYTES*8-1:0]        a_data,
    input  logic [VEC_BYTES*8-1:0]        b_data,
    input  logic [VEC_BYTES-1:0]          a_none,
    input  logic [VEC_BYTES-1:0]          a_nar,
    input  logic [VEC_BYTES-1:0]          b_none,
    input  logic [VEC_BYTES-1:0]          b_nar,
    input  logic                          sgn,
    input  logic                          sat,
    output logic [VEC_BYTES*8-1:0]        y_data,
    output logic [VEC_BYTES-1:0]          y_none,
    output logic [VEC_BYTES-1:0]          y_nar,
    output logic [VEC_BYTES/IN_BYTES-1:0] ovf_a,
    output logic [VEC_BYTES/IN_BYTES-1:0] ovf_b
);
    localparam int NE   = VEC_BYTES / IN_BYTES;
    localparam int IB   = IN_BYTES * 8;
    localparam int OBY  = IN_BYTES / 2;
    localparam int OBIT = OBY * 8;
    localparam int HALF = VEC_BYTES / 2;

    for (genvar k = 0; k < NE; k++) begin : g_el
        vn_elem #(.IN_BITS(IB)) u_ea (
            .din(a_data[k*IB +: IB]), .sgn(sgn), .sat(sat),
            .dout(y_data[k*OBIT +: OBIT]), .ovf(ovf_a[k]));
        vn_elem #(.IN_BITS(IB)) u_eb (
            .din(b_data[k*IB +: IB]), .sgn(sgn), .sat(sat),
            .dout(y_data[HALF*8 + k*OBIT +: OBIT]), .ovf(ovf_b[k]));
    end

    // Move base-lane tags to the base lanes of the output elements
    always_comb begin
        y_none = '0;
        y_nar  = '0;
        for (int k = 0; k < NE; k++) begin
            y_none[k*OBY]        = a_none[k*IN_BYTES];
            y_nar[k*OBY]         = a_nar[k*IN_BYTES];
            y_none[HALF + k*OBY] = b_none[k*IN_BYTES];
            y_nar[HALF + k*OBY]  = b_nar[k*IN_BYTES];
        end
    end

    logic unused_tag_lanes;
    assign unused_tag_lanes = ^{a_none, a_nar, b_none, b_nar};
endmodule

// File: rtl/vec_narrow_unit.sv
// Top of the vector narrowing unit: one packer per legal input width,
// width selection, scalar masking, fault decision and a result register.
// Assumes VEC_BYTES is a power of two of at least 8.
module vec_narrow_unit #(
    parameter int VEC_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_scalar,
    input  logic                   in_signed,
    input  logic [1:0]             in_mode,
    input  logic [VEC_BYTES*8-1:0] a_data,
    input  logic [1:0]             a_wcode,
    input  logic [VEC_BYTES-1:0]   a_none,
    input  logic [VEC_BYTES-1:0]   a_nar,
    input  logic [VEC_BYTES*8-1:0] b_data,
    input  logic [1:0]             b_wcode,
    input  logic [VEC_BYTES-1:0]   b_none,
    input  logic [VEC_BYTES-1:0]   b_nar,
    output logic                   out_valid,
    output logic                   out_fault,
    output logic [VEC_BYTES*8-1:0] y_data,
    output logic [1:0]             y_wcode,
    output logic [VEC_BYTES-1:0]   y_none,
    output logic [VEC_BYTES-1:0]   y_nar
);
    import vn_pkg::*;

    localparam int VBITS = VEC_BYTES * 8;

    wcode_t  wc;
    ovmode_t md;
    assign wc = wcode_t'(a_wcode);
    assign md = ovmode_t'(in_mode);

    logic [VBITS-1:0]     pk_data [1:3];
    logic [VEC_BYTES-1:0] pk_none [1:3];
    logic [VEC_BYTES-1:0] pk_nar  [1:3];
    logic [3:1]           pk_ovf_any;
    logic [3:1]           pk_ovf0;

    for (genvar g = 1; g <= 3; g++) begin : g_width
        localparam int EB = 1 << g;
        logic [VEC_BYTES/EB-1:0] oa;
        logic [VEC_BYTES/EB-1:0] ob;
        vn_pack #(.VEC_BYTES(VEC_BYTES), .IN_BYTES(EB)) u_pack (
            .a_data(a_data), .b_data(b_data),
            .a_none(a_none), .a_nar(a_nar), .b_none(b_none), .b_nar(b_nar),
            .sgn(in_signed), .sat(md == OV_SAT),
            .y_data(pk_data[g]), .y_none(pk_none[g]), .y_nar(pk_nar[g]),
            .ovf_a(oa), .ovf_b(ob));
        assign pk_ovf_any[g] = |{oa, ob};
        assign pk_ovf0[g]    = oa[0];
    end

    logic [VBITS-1:0]     sel_data;
    logic [VEC_BYTES-1:0] sel_none;
    logic [VEC_BYTES-1:0] sel_nar;
    logic                 sel_ovf;
    logic                 bad;
    int                   half_bytes;

    // Pick the packer for the operand width and apply the scalar form
    always_comb begin
        sel_data   = '0;
        sel_none   = '0;
        sel_nar    = '0;
        sel_ovf    = 1'b0;
        half_bytes = 0;
        case (wc)
            WC_2B: begin sel_data = pk_data[1]; sel_none = pk_none[1]; sel_nar = pk_nar[1];
                         sel_ovf = in_scalar ? pk_ovf0[1] : pk_ovf_any[1]; half_bytes = 1; end
            WC_4B: begin sel_data = pk_data[2]; sel_none = pk_none[2]; sel_nar = pk_nar[2];
                         sel_ovf = in_scalar ? pk_ovf0[2] : pk_ovf_any[2]; half_bytes = 2; end
            WC_8B: begin sel_data = pk_data[3]; sel_none = pk_none[3]; sel_nar = pk_nar[3];
                         sel_ovf = in_scalar ? pk_ovf0[3] : pk_ovf_any[3]; half_bytes = 4; end
            default: ;
        endcase
        if (in_scalar) begin
            for (int l = 0; l < VEC_BYTES; l++) begin
                if (l >= half_bytes) sel_data[l*8 +: 8] = 8'h00;
                if (l != 0) begin
                    sel_none[l] = 1'b0;
                    sel_nar[l]  = 1'b0;
                end
            end
        end
    end

    // Decide whether the request must fault instead of producing data
    always_comb begin
        bad = (wc == WC_1B) || (md == OV_RSV) || (md == OV_FAULT && sel_ovf)
              || (!in_scalar && (b_wcode != a_wcode));
    end

    // Result register with one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            y_data    <= '0;
            y_wcode   <= '0;
            y_none    <= '0;
            y_nar     <= '0;
        end else begin
            out_valid <= in_valid && !bad;
            out_fault <= in_valid && bad;
            if (in_valid && !bad) begin
                y_data  <= sel_data;
                y_wcode <= a_wcode - 2'd1;
                y_none  <= sel_none;
                y_nar   <= sel_nar;
            end else begin
                y_data  <= '0;
                y_wcode <= '0;
                y_none  <= '0;
                y_nar   <= '0;
            end
        end
    end

    AST_WIDTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (y_wcode == $past(a_wcode) - 2'd1)); // R1
    AST_MIN_WIDTH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_wcode == 2'd0) |=> out_fault); // R2
    AST_MISMATCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_scalar && a_wcode != b_wcode) |=> out_fault); // R3
    AST_RSV_MODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd3) |=> out_fault); // R7
    AST_SCALAR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_scalar) |=> (y_data[VBITS-1:VBITS/2] == '0)); // R10
    AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_fault)); // R12
endmodule

// File: tb/sim_vec_narrow_unit.sv
`timescale 1ns/1ps
module sim_vec_narrow_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_scalar, in_signed;
    logic [1:0]   in_mode, a_wcode, b_wcode;
    logic [127:0] a_data, b_data;
    logic [15:0]  a_none, a_nar, b_none, b_nar;
    logic         out_valid, out_fault;
    logic [127:0] y_data;
    logic [1:0]   y_wcode;
    logic [15:0]  y_none, y_nar;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vec_narrow_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_scalar(in_scalar),
        .in_signed(in_signed), .in_mode(in_mode),
        .a_data(a_data), .a_wcode(a_wcode), .a_none(a_none), .a_nar(a_nar),
        .b_data(b_data), .b_wcode(b_wcode), .b_none(b_none), .b_nar(b_nar),
        .out_valid(out_valid), .out_fault(out_fault), .y_data(y_data),
        .y_wcode(y_wcode), .y_none(y_none), .y_nar(y_nar));

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = 0; in_scalar = 0; in_signed = 1; in_mode = 0;
        a_data = '0; b_data = '0; a_wcode = 2; b_wcode = 2;
        a_none = '0; a_nar = '0; b_none = '0; b_nar = '0;
    endtask

    // Apply the prepared request for one edge and sample just after it
    task automatic fire();
        in_valid = 1;
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic t_reset();
        chk("R11 valid", {127'b0, out_valid}, 128'd0);
        chk("R11 fault", {127'b0, out_fault}, 128'd0);
        chk("R11 data", y_data, 128'd0);
        chk("R11 tags", {96'b0, y_none, y_nar}, 128'd0);
    endtask

    task automatic t_vector_orders();
        clear_in();
        a_wcode = 2; b_wcode = 2;
        a_data = 128'h00000044_00000033_00000022_00000011;
        b_data = 128'h00000088_00000077_00000066_00000055;
        fire();
        chk("R1 valid", {127'b0, out_valid}, 128'd1);
        chk("R1 word to short", y_data, 128'h0088_0077_0066_0055_0044_0033_0022_0011);
        chk("R1 wcode", {126'b0, y_wcode}, 128'd1);
        clear_in();
        a_wcode = 3; b_wcode = 3;
        a_data = {64'h2, 64'h1}; b_data = {64'h4, 64'h3};
        fire();
        chk("R1 dword to word", y_data, {32'h4, 32'h3, 32'h2, 32'h1});
        chk("R1 wcode 8B", {126'b0, y_wcode}, 128'd2);
        clear_in();
        a_wcode = 1; b_wcode = 1;
        a_data = 128'h0008_0007_0006_0005_0004_0003_0002_0001;
        b_data = 128'h0010_000F_000E_000D_000C_000B_000A_0009;
        fire();
        chk("R1 short to byte", y_data, 128'h100F0E0D0C0B0A09_0807060504030201);
    endtask

    task automatic t_truncate();
        clear_in();
        in_mode = 0;
        a_data = {96'h0, 32'h12345678};
        fire();
        chk("R4 valid", {127'b0, out_valid}, 128'd1);
        chk("R4 low bits", y_data, {112'h0, 16'h5678});
    endtask

    task automatic t_fault_mode();
        clear_in();
        in_mode = 1;
        a_data = {96'h0, 32'h12345678};
        fire();
        chk("R5 fault", {127'b0, out_fault}, 128'd1);
        chk("R12 no valid", {127'b0, out_valid}, 128'd0);
        chk("R12 zero data", y_data, 128'd0);
    endtask

    task automatic t_signedness();
        clear_in();
        in_mode = 1; in_signed = 1;
        a_data = {96'h0, 32'hFFFFFFFF};
        fire();
        chk("R8 signed -1 fits", {126'b0, out_fault, out_valid}, 128'd1);
        chk("R8 signed -1 data", y_data, {112'h0, 16'hFFFF});
        clear_in();
        in_mode = 1; in_signed = 0;
        a_data = {96'h0, 32'h0000FFFF};
        fire();
        chk("R8 unsigned fits", {126'b0, out_fault, out_valid}, 128'd1);
        clear_in();
        in_mode = 1; in_signed = 1;
        a_data = {96'h0, 32'h0000FFFF};
        fire();
        chk("R8 signed overflow", {126'b0, out_fault, out_valid}, 128'd2);
    endtask

    task automatic t_saturate();
        clear_in();
        in_mode = 2; in_signed = 1;
        a_data = {32'h0, 32'h5, 32'h80000000, 32'h12345678};
        fire();
        chk("R6 signed clamp", y_data, {64'h0, 16'h0000, 16'h0005, 16'h8000, 16'h7FFF});
        clear_in();
        in_mode = 2; in_signed = 0;
        a_data = {32'h0, 32'h5, 32'h80000000, 32'h12345678};
        fire();
        chk("R6 unsigned clamp", y_data, {64'h0, 16'h0000, 16'h0005, 16'hFFFF, 16'hFFFF});
    endtask

    task automatic t_illegal();
        clear_in();
        in_mode = 3;
        fire();
        chk("R7 reserved mode", {126'b0, out_fault, out_valid}, 128'd2);
        clear_in();
        a_wcode = 0; b_wcode = 0;
        fire();
        chk("R2 byte operand", {126'b0, out_fault, out_valid}, 128'd2);
        clear_in();
        a_wcode = 2; b_wcode = 3;
        fire();
        chk("R3 mismatch", {126'b0, out_fault, out_valid}, 128'd2);
        chk("R12 zero wcode", {126'b0, y_wcode}, 128'd0);
    endtask

    task automatic t_tags();
        clear_in();
        a_nar  = 16'h0030;
        b_none = 16'h0001;
        a_none = 16'h0002;
        fire();
        chk("R9 nar", {112'b0, y_nar}, {112'b0, 16'h0004});
        chk("R9 none", {112'b0, y_none}, {112'b0, 16'h0100});
    endtask

    task automatic t_scalar();
        clear_in();
        in_scalar = 1; in_mode = 1; a_wcode = 3; b_wcode = 0;
        a_data = {64'hDEADBEEF_CAFEF00D, 64'h00000000_7FFFFFFF};
        b_data = {128{1'b1}};
        a_none = 16'h0101;
        b_nar  = 16'hFFFF;
        fire();
        chk("R10 valid", {126'b0, out_fault, out_valid}, 128'd1);
        chk("R10 data", y_data, {96'h0, 32'h7FFFFFFF});
        chk("R10 wcode", {126'b0, y_wcode}, 128'd2);
        chk("R10 tags", {96'b0, y_none, y_nar}, {96'b0, 16'h0001, 16'h0000});
    endtask

    task automatic t_idle();
        clear_in();
        a_wcode = 0;
        @(posedge clk); #1;
        chk("R12 idle", {126'b0, out_fault, out_valid}, 128'd0);
    endtask

    initial begin
        clear_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        @(posedge clk); #1;
        t_vector_orders();
        t_truncate();
        t_fault_mode();
        t_signedness();
        t_saturate();
        t_illegal();
        t_tags();
        t_scalar();
        t_idle();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule